// File: doc/BRIEF.md
# Predictor-Gated Unsigned Greater-Than Comparator

This block registers two unsigned operands and reports whether the first is strictly greater than the second. It saves switching energy by checking the top bit of each operand as it arrives. When those two bits differ, they settle the answer on their own. The register bank that holds the remaining low-order bits is then not loaded, so the wide comparison logic behind it sees no new values.

When the top bits are equal, the low-order bank loads as usual and the full-width compare produces the answer. The result and its valid flag appear one clock cycle after an operand pair is accepted. A saturating counter reports how many accepted pairs skipped the low-order load. This lets the surrounding logic, or a test, confirm that gating really takes place.

Top module: `pgate_gt_cmp`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0, `res_gt` is 0 and `skip_count` is 0.
- R2: `res_valid` is 1 in the cycle after a cycle with `op_valid` high, and 0 in the cycle after a cycle with `op_valid` low.
- R3: If `op_a[W-1]` is 1 and `op_b[W-1]` is 0 on an accepted pair, `res_gt` is 1 one cycle later, whatever the lower bits are.
- R4: If `op_a[W-1]` is 0 and `op_b[W-1]` is 1 on an accepted pair, `res_gt` is 0 one cycle later, whatever the lower bits are.
- R5: If the top bits of an accepted pair are equal, `res_gt` one cycle later equals the unsigned result of `op_a > op_b` over all W bits.
- R6: Equal operands give `res_gt` = 0, including all-zero and all-one pairs.
- R7: `skip_count` rises by exactly one for each accepted pair whose top bits differ. It does not change for accepted pairs with equal top bits, or on cycles with `op_valid` low.
- R8: `skip_count` saturates at 2^CNT_W-1 and stays there while further skipping pairs arrive.
- R9: While `op_valid` is low, `res_gt` keeps its last value, whatever happens on `op_a` and `op_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand pair on op_a/op_b is accepted this cycle |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| res_gt | output | 1 | 1 when the last accepted op_a exceeds op_b |
| res_valid | output | 1 | res_gt belongs to the pair accepted in the previous cycle |
| skip_count | output | CNT_W | Saturating count of pairs that skipped the low-order load |

## Verification
Two functions can act in the same cycle: a predictor-decided result and the bookkeeping of the skip counter, including its saturation. The saturation scenario sends hundreds of back-to-back pairs whose top bits differ, with random lower bits. In every cycle it checks that the result follows the predictor, and that the counter first climbs by one per pair and then stays at its ceiling. A mixed random run interleaves equal-top and differing-top pairs. There a load of the low-order bank right after a stale, held one must still produce the exact full-width answer.

// File: rtl/pgate_gt_pkg.sv
package pgate_gt_pkg;
  typedef enum logic [1:0] {
    DEC_FULL = 2'd0,
    DEC_GT   = 2'd1,
    DEC_LE   = 2'd2
  } decide_t;

  function automatic decide_t predict(input logic top_a, input logic top_b);
    if (top_a && !top_b)      return DEC_GT;
    else if (!top_a && top_b) return DEC_LE;
    else                      return DEC_FULL;
  endfunction
endpackage

// File: rtl/pgate_top_predict.sv
module pgate_top_predict
  import pgate_gt_pkg::*;
(
  input  logic    top_a,
  input  logic    top_b,
  output decide_t decision,
  output logic    need_full
);
  always_comb begin
    decision  = predict(top_a, top_b);
    need_full = (decision == DEC_FULL);
  end
endmodule

// File: rtl/pgate_low_bank.sv
module pgate_low_bank #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] lo_a_in,
  input  logic [LW-1:0] lo_b_in,
  output logic [LW-1:0] lo_a_q,
  output logic [LW-1:0] lo_b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_a_q <= '0;
      lo_b_q <= '0;
    end else if (load) begin
      lo_a_q <= lo_a_in;
      lo_b_q <= lo_b_in;
    end
  end

  // R7 gating: a suppressed load leaves the bank untouched
  a_r7_bank_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(lo_a_q) && $stable(lo_b_q)));
endmodule

// File: rtl/pgate_full_cmp.sv
module pgate_full_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         x_gt_y
);
  logic [W:0]   eq_above;
  logic [W-1:0] win_at;

  assign eq_above[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign eq_above[i] = eq_above[i+1] & (x[i] ~^ y[i]);
    assign win_at[i]   = eq_above[i+1] & x[i] & ~y[i];
  end

  assign x_gt_y = |win_at;
endmodule

// File: rtl/pgate_skip_counter.sv
module pgate_skip_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (bump && count != CNT_MAX) count <= count + 1'b1;
  end

  a_r7_bump_once: assert property (@(posedge clk) disable iff (rst)
    (bump && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
  a_r7_no_bump: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(count));
  a_r8_pinned: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/pgate_gt_cmp.sv
module pgate_gt_cmp
  import pgate_gt_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic             res_gt,
  output logic             res_valid,
  output logic [CNT_W-1:0] skip_count
);
  localparam int MSB = W - 1;
  localparam int LW  = W - 1;

  decide_t       dec_in, dec_q;
  logic          need_full;
  logic          top_a_q, top_b_q;
  logic [LW-1:0] lo_a_q, lo_b_q;
  logic          full_gt;
  logic          low_load;
  logic          skip_bump;

  pgate_top_predict u_pred (
    .top_a     (op_a[MSB]),
    .top_b     (op_b[MSB]),
    .decision  (dec_in),
    .need_full (need_full)
  );

  assign low_load  = op_valid &&  need_full;
  assign skip_bump = op_valid && !need_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_a_q   <= 1'b0;
      top_b_q   <= 1'b0;
      dec_q     <= DEC_FULL;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        top_a_q <= op_a[MSB];
        top_b_q <= op_b[MSB];
        dec_q   <= dec_in;
      end
    end
  end

  pgate_low_bank #(.LW(LW)) u_low (
    .clk     (clk),
    .rst     (rst),
    .load    (low_load),
    .lo_a_in (op_a[LW-1:0]),
    .lo_b_in (op_b[LW-1:0]),
    .lo_a_q  (lo_a_q),
    .lo_b_q  (lo_b_q)
  );

  pgate_full_cmp #(.W(W)) u_cmp (
    .x      ({top_a_q, lo_a_q}),
    .y      ({top_b_q, lo_b_q}),
    .x_gt_y (full_gt)
  );

  always_comb begin
    unique case (dec_q)
      DEC_GT:  res_gt = 1'b1;
      DEC_LE:  res_gt = 1'b0;
      default: res_gt = full_gt;
    endcase
  end

  pgate_skip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .bump  (skip_bump),
    .count (skip_count)
  );

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (res_valid == $past(op_valid)));
  a_r3_top_wins: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_a[MSB] && !op_b[MSB]) |=> res_gt);
  a_r4_top_loses: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_a[MSB] && op_b[MSB]) |=> !res_gt);
  a_r5_full_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_a[MSB] == op_b[MSB])) |=> (res_gt == ($past(op_a) > $past(op_b))));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_gt));
endmodule

// File: tb/pgate_gt_cmp_test.sv
module pgate_gt_cmp_test;
  localparam int W      = 8;
  localparam int CNT_W  = 8;
  localparam int PERIOD = 10;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             clk = 1'b0;
  logic             rst;
  logic             op_valid;
  logic [W-1:0]     op_a, op_b;
  logic             res_gt, res_valid;
  logic [CNT_W-1:0] skip_count;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt  = 0;
  logic last_z = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pgate_gt_cmp #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .res_gt(res_gt), .res_valid(res_valid), .skip_count(skip_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one accepted pair, checked at the following negedge
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    op_a = a; op_b = b; op_valid = 1'b1;
    if (a[W-1] != b[W-1] && exp_cnt < int'(CMAX)) exp_cnt++;
    @(negedge clk);
    op_valid = 1'b0;
    last_z = (a > b);
    check({req, " result"}, res_gt, last_z);
    check("R2 valid", res_valid, 1);
    check("R7 count", skip_count, exp_cnt);
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; op_a = '1; op_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 valid", res_valid, 0);
    check("R1 result", res_gt, 0);
    check("R1 count", skip_count, 0);
    exp_cnt = 0;
  endtask

  task automatic t_top_differ();
    send(8'h80, 8'h7F, "R3");
    send(8'h80, 8'h00, "R3");
    send(8'hC3, 8'h3C, "R3");
    send(8'h7F, 8'h80, "R4");
    send(8'h00, 8'hFF, "R4");
    send(8'h01, 8'h81, "R4");
  endtask

  task automatic t_top_equal();
    send(8'h05, 8'h04, "R5");
    send(8'h04, 8'h05, "R5");
    send(8'hFE, 8'hFD, "R5");
    send(8'h81, 8'hFF, "R5");
    send(8'h40, 8'h3F, "R5");
    send(8'h00, 8'h00, "R6");
    send(8'hFF, 8'hFF, "R6");
    send(8'h5A, 8'h5A, "R6");
    // stale bank from a skipped pair must not leak into a full compare
    send(8'hFF, 8'h00, "R3");
    send(8'h12, 8'h11, "R5");
  endtask

  task automatic t_idle_hold();
    send(8'h90, 8'h10, "R3");
    op_a = 8'h00; op_b = 8'hFF;
    @(negedge clk);
    check("R2 idle valid", res_valid, 0);
    check("R9 held result", res_gt, 1);
    check("R7 idle count", skip_count, exp_cnt);
    send(8'h22, 8'h33, "R5");
    op_a = 8'hFF; op_b = 8'h00;
    repeat (2) @(negedge clk);
    check("R9 held result", res_gt, 0);
    check("R7 idle count", skip_count, exp_cnt);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      if (i % 3 == 0) b[W-1] = a[W-1];
      send(a, b, (a[W-1] == b[W-1]) ? "R5" : "R3/R4");
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      b[W-1] = ~a[W-1];
      send(a, b, "R8 predicted");
    end
    check("R8 saturated", skip_count, CMAX);
    send(8'h10, 8'h20, "R5");
    check("R8 equal-top keeps max", skip_count, CMAX);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_top_differ();
    t_top_equal();
    t_idle_hold();
    t_random();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule